// File: doc/BRIEF.md
# Backplane Interrupt Request Register

This block is a single byte-wide register that host software uses to raise one of seven backplane interrupt request levels. Software writes a level number from 1 to 7 into the low three bits, and the matching active-low request line is driven low. Writing zero withdraws the request. When the interrupt handler on the bus acknowledges that same level, the block clears the level field by itself and releases the line.

The register reads back the current level in its low bits. The top bit is a read-only copy of a static configuration jumper, inverted. The bits in between read as zero. A synchronous system reset and a soft reset input both clear the level. All outputs are registered and change on the clock edge that commits the new level.

Top module: `irq_request_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the level is cleared. After that edge all `irq_req_n` lines are high and `rd_data[2:0]` reads 0.
- R2: A write of level n (1 to 7) in `wr_data[2:0]` drives `irq_req_n[n-1]` low and all other lines high, starting at the same clock edge.
- R3: A write of level 0 releases every request line at that clock edge.
- R4: `ack_valid` with `ack_level` equal to the nonzero current level clears the level at that clock edge, which releases the line.
- R5: `ack_valid` with `ack_level` different from the current level changes neither the level nor any request line.
- R6: When a write and a matching acknowledge occur in the same cycle, the written level is taken.
- R7: While `soft_rst` is high at a clock edge, the level is cleared, and any write in that cycle is ignored.
- R8: `rd_data[6:3]` always reads 0. Writes to those bits have no effect on any output.
- R9: `rd_data[7]` equals the inverse of `slot1_jumper_fitted` as sampled at the previous clock edge. It reads 0 when the jumper is fitted and 1 when it is absent.
- R10: At most one `irq_req_n` line is low at any time.
- R11: `rd_data[2:0]` shows the level committed at the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| soft_rst | input | 1 | Soft reset; clears the level while high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bits 2:0 are the level |
| ack_valid | input | 1 | Interrupt acknowledge cycle present |
| ack_level | input | 3 | Level being acknowledged |
| slot1_jumper_fitted | input | 1 | Static jumper, 1 when fitted |
| irq_req_n | output | 7 | Active-low request lines; bit i is level i+1 |
| rd_data | output | 8 | Register read image |

## Verification
Every result lands exactly one clock edge after the inputs that cause it. This covers the request lines, the level readback and the jumper bit, because each one is a flop loaded from the same next-state value. The bench drives its inputs one time unit after a rising edge and holds them through the next edge. It then advances its behavioural model at that edge and compares every output one time unit later. Both sides therefore use the same single-edge latency, with no reliance on process order at the edge.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_CLEAR = 2'd1,
    UPD_LOAD  = 2'd2
  } upd_e;
endpackage

// File: rtl/irq_level_ctl.sv
module irq_level_ctl
  import irq_req_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_level,
  input  logic             ack_valid,
  input  logic [LVL_W-1:0] ack_level,
  output logic [LVL_W-1:0] level_next,
  output logic [LVL_W-1:0] level_q
);
  upd_e upd;
  logic ack_hit;

  assign ack_hit = ack_valid && (level_q != '0) && (ack_level == level_q);

  // priority: reset, soft reset, write, matching acknowledge
  always_comb begin
    if (rst || soft_rst) upd = UPD_CLEAR;
    else if (wr_en)      upd = UPD_LOAD;
    else if (ack_hit)    upd = UPD_CLEAR;
    else                 upd = UPD_HOLD;
  end

  always_comb begin
    unique case (upd)
      UPD_CLEAR: level_next = '0;
      UPD_LOAD:  level_next = wr_level;
      default:   level_next = level_q;
    endcase
  end

  always_ff @(posedge clk) begin
    level_q <= level_next;
  end
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int LVL_W     = 3,
  parameter int NUM_LINES = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LVL_W-1:0]     level_next,
  output logic [NUM_LINES-1:0] irq_req_n
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq_req_n[i] <= 1'b1;
      else     irq_req_n[i] <= !(level_next == LVL_W'(i + 1));
    end
  end
endmodule

// File: rtl/irq_read_image.sv
module irq_read_image #(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [LVL_W-1:0]  level_next,
  input  logic              jumper_fitted,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] image;

  always_comb begin
    image                = '0;
    image[LVL_W-1:0]     = level_next;
    image[DATA_W-1]      = ~jumper_fitted;
  end

  always_ff @(posedge clk) begin
    rd_data <= image;
  end
endmodule

// File: rtl/irq_request_reg.sv
module irq_request_reg #(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        soft_rst,
  input  logic                        wr_en,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        ack_valid,
  input  logic [LVL_W-1:0]            ack_level,
  input  logic                        slot1_jumper_fitted,
  output logic [(1<<LVL_W)-2:0]       irq_req_n,
  output logic [DATA_W-1:0]           rd_data
);
  localparam int NUM_LINES = (1 << LVL_W) - 1;

  logic [LVL_W-1:0] level_next;
  logic [LVL_W-1:0] level_q;

  irq_level_ctl #(.LVL_W(LVL_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .wr_en      (wr_en),
    .wr_level   (wr_data[LVL_W-1:0]),
    .ack_valid  (ack_valid),
    .ack_level  (ack_level),
    .level_next (level_next),
    .level_q    (level_q)
  );

  irq_line_drv #(.LVL_W(LVL_W), .NUM_LINES(NUM_LINES)) u_lines (
    .clk        (clk),
    .rst        (rst),
    .level_next (level_next),
    .irq_req_n  (irq_req_n)
  );

  irq_read_image #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_img (
    .clk           (clk),
    .level_next    (level_next),
    .jumper_fitted (slot1_jumper_fitted),
    .rd_data       (rd_data)
  );
endmodule

// File: rtl/irq_request_reg_chk.sv
module irq_request_reg_chk #(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  soft_rst,
  input logic                  wr_en,
  input logic [DATA_W-1:0]     wr_data,
  input logic                  ack_valid,
  input logic [LVL_W-1:0]      ack_level,
  input logic                  slot1_jumper_fitted,
  input logic [(1<<LVL_W)-2:0] irq_req_n,
  input logic [DATA_W-1:0]     rd_data
);
  // R10
  one_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~irq_req_n));

  // R7
  soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (&irq_req_n) && (rd_data[LVL_W-1:0] == '0));

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !wr_en && !soft_rst && rd_data[LVL_W-1:0] != '0 &&
     ack_level == rd_data[LVL_W-1:0]) |=> &irq_req_n);

  // R5
  ack_other_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !wr_en && !soft_rst && ack_level != rd_data[LVL_W-1:0])
      |=> $stable(irq_req_n));

  // R6
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !soft_rst) |=> rd_data[LVL_W-1:0] == $past(wr_data[LVL_W-1:0]));

  // R8
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !soft_rst) |=> rd_data[DATA_W-2:LVL_W] == '0);

  // R9
  jumper_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rd_data[DATA_W-1] == !$past(slot1_jumper_fitted));
endmodule

bind irq_request_reg irq_request_reg_chk #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk                 (clk),
  .rst                 (rst),
  .soft_rst            (soft_rst),
  .wr_en               (wr_en),
  .wr_data             (wr_data),
  .ack_valid           (ack_valid),
  .ack_level           (ack_level),
  .slot1_jumper_fitted (slot1_jumper_fitted),
  .irq_req_n           (irq_req_n),
  .rd_data             (rd_data)
);

// File: tb/irq_request_reg_test.sv
module irq_request_reg_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_rst = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_level = '0;
  logic       slot1_jumper_fitted = 1'b1;
  logic [6:0] irq_req_n;
  logic [7:0] rd_data;

  int tests = 0;
  int fails = 0;
  int m_lvl = 0;
  bit m_jump = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_request_reg uut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en), .wr_data(wr_data),
    .ack_valid(ack_valid), .ack_level(ack_level),
    .slot1_jumper_fitted(slot1_jumper_fitted),
    .irq_req_n(irq_req_n), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock edge: model advances at the edge, outputs compared 1 ns later
  task automatic step(input string tag);
    logic [6:0] e_irq;
    logic [7:0] e_rd;
    @(posedge clk);
    if (rst || soft_rst)  m_lvl = 0;
    else if (wr_en)       m_lvl = int'(wr_data[2:0]);
    else if (ack_valid && m_lvl != 0 && int'(ack_level) == m_lvl) m_lvl = 0;
    m_jump = slot1_jumper_fitted;
    #1;
    for (int i = 0; i < 7; i++) e_irq[i] = (m_lvl != i + 1);
    e_rd = {~m_jump, 4'b0000, 3'(m_lvl)};
    check({tag, " irq"}, {1'b0, irq_req_n}, {1'b0, e_irq});
    check({tag, " rd"}, rd_data, e_rd);
    check("R10 onehot", {7'd0, $countones(~irq_req_n) <= 1}, 8'd1);
  endtask

  task automatic idle_inputs();
    rst = 0; soft_rst = 0; wr_en = 0; ack_valid = 0;
  endtask

  initial begin
    step("R1"); step("R1");
    idle_inputs();
    step("R1");
    // R2 / R5 / R4 for each level
    for (int n = 1; n < 8; n++) begin
      wr_en = 1; wr_data = 8'(n); step("R2");
      wr_en = 0; ack_valid = 1; ack_level = 3'((n % 7) + 1); step("R5");
      ack_level = 3'(n); step("R4");
      ack_valid = 0; step("R4");
    end
    // R3
    wr_en = 1; wr_data = 8'd3; step("R2");
    wr_data = 8'd0; step("R3");
    // R8: upper bits written
    wr_data = 8'hFD; step("R8");
    wr_data = 8'h78; step("R8");
    // R6: write with matching ack
    wr_data = 8'd6; step("R2");
    ack_valid = 1; ack_level = 3'd6; wr_data = 8'd2; step("R6");
    wr_en = 0; ack_valid = 0; step("R11");
    // R7: soft reset beats write
    soft_rst = 1; wr_en = 1; wr_data = 8'd5; step("R7");
    soft_rst = 0; wr_en = 0; step("R7");
    // R9 jumper
    slot1_jumper_fitted = 0; step("R9");
    slot1_jumper_fitted = 1; step("R9");
    // R1 mid-run reset
    wr_en = 1; wr_data = 8'd4; step("R2");
    wr_en = 0; rst = 1; step("R1");
    rst = 0; step("R1");
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      soft_rst = ($urandom_range(0, 19) == 0);
      wr_en = ($urandom_range(0, 3) == 0);
      wr_data = 8'($urandom);
      ack_valid = ($urandom_range(0, 2) == 0);
      ack_level = (ack_valid && $urandom_range(0, 1) == 1) ? 3'(m_lvl) : 3'($urandom);
      slot1_jumper_fitted = ($urandom_range(0, 9) != 0);
      step("R11");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule